// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a two-wire serial slave that gives a host controller access to a bank of 8-bit control registers. The host drives a serial clock and a serial data line into the block. The block answers on a separate response pin instead of pulling down a shared line. Both bus inputs are oversampled by the fast system clock through a synchronizer. All framing is decoded from the edges seen in the system clock domain.

A transfer opens with a start condition and closes with a stop condition. Each byte takes nine bus clocks. The first byte selects the device and the direction. In a write, the second byte loads an internal pointer, and every later byte is stored at the pointer, which then advances. To read, the host first writes the pointer, then opens a new transfer with the read address. The block then shifts register contents out on the response pin, inverted and MSB first, until the host declines to acknowledge. The register contents are available to the rest of the chip through a combinational lookup port.

Top module: `ser_regbank`

## Requirements
- R1: A fall of the data input while the bus clock is high opens a transfer. A rise of the data input while the bus clock is high closes it and forces the response pin low. Bytes clocked in without an open transfer write nothing and get no acknowledge.
- R2: Each byte is shifted in MSB first over eight bus clocks, followed by a ninth acknowledge slot.
- R3: A first byte of 24h (write) or 25h (read) is acknowledged by the response pin going high during the ninth slot.
- R4: A first byte with any other value gets no acknowledge. The block then stays silent and writes nothing until the next start condition.
- R5: In a write, the second byte loads the pointer from its low seven bits. Every later byte is stored at the pointer, and the pointer then advances by one.
- R6: The pointer advances from 7Fh to 00h, both when writing and when reading.
- R7: The response pin is high in the ninth slot after each pointer byte and each data byte that the block receives.
- R8: In a read, the register at the pointer is driven on the response pin inverted and MSB first, each bit changing after a falling bus clock edge, and the pointer then advances.
- R9: In a read, the response pin is low during the ninth slot. A low data input from the host in that slot continues with the next register. A high one ends the readout, and the pin stays low until the next start.
- R10: An active-low reset clears every register to 00h and holds the response pin low.
- R11: The lookup port returns the current content of the register it addresses, without a clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Serial bus clock from the host |
| bus_dat | input | 1 | Serial bus data from the host |
| bus_resp | output | 1 | Acknowledge and inverted readout to the host |
| tap_addr | input | 7 | Register index for the lookup port |
| tap_data | output | 8 | Content of the register at tap_addr |

## Verification
The bench builds the block with its default parameters: a 7-bit pointer over 128 registers, 8-bit data, device code 12h (bus bytes 24h and 25h) and a two-stage synchronizer. With the full 128-entry bank, the pointer's 7Fh-to-00h step can be reached by both the write path and the read path in a few bytes. With the 8-bit width, the sequence of inverted readout bits can be compared byte by byte against what was written. The bus runs at a quarter-period of six system clocks. This leaves room for the synchronizer and edge-detect latency before each response sample, so each acknowledge slot and readout bit is sampled while its value is stable.

// File: rtl/ser_regbank_pkg.sv
package ser_regbank_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PTR,
      ST_WDATA,
      ST_RDATA
   } link_st_t;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
   parameter int WIDTH = 2,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ser_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/ser_regfile.sv
module ser_regfile #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [ADDR_W-1:0] tap_addr,
   output logic [DATA_W-1:0] tap_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_depth
      $error("ser_regfile: ADDR_W out of range");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data  = mem[rd_addr];
   assign tap_data = mem[tap_addr];

   // R5
   wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/ser_link.sv
module ser_link
   import ser_regbank_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-2:0] DEV_ID = 7'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic              resp,
   output logic              wr_en,
   output logic [ADDR_W-1:0] ptr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int CNT_W = $clog2(DATA_W + 2);
   localparam int BSEL_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] SLOT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] DONE = CNT_W'(DATA_W + 1);
   localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(DATA_W - 1);
   localparam logic [DATA_W-1:0] WR_CODE = {DEV_ID, 1'b0};
   localparam logic [DATA_W-1:0] RD_CODE = {DEV_ID, 1'b1};

   if (DATA_W < 2 || ADDR_W > DATA_W) begin : g_bad_width
      $error("ser_link: DATA_W must be >= 2 and >= ADDR_W");
   end

   link_st_t          st;
   logic              scl_q, sda_q;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg, txbuf;
   logic              mnack, first_rd;
   logic [BSEL_W-1:0] bsel;

   wire start_det = scl_s & scl_q & sda_q & ~sda_s;
   wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
   wire rise      = scl_s & ~scl_q;
   wire fall      = ~scl_s & scl_q;

   always_comb bsel = BSEL_W'(TOP_BIT - cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;   scl_q <= 1'b1;  sda_q <= 1'b1;
         cnt <= '0;       shreg <= '0;    txbuf <= '0;
         mnack <= 1'b1;   first_rd <= 1'b0;
         resp <= 1'b0;    wr_en <= 1'b0;  wr_data <= '0;
         ptr <= '0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         wr_en <= 1'b0;
         if (wr_en) ptr <= ptr + ADDR_W'(1);
         if (start_det) begin
            st <= ST_ADDR;  cnt <= '0;  resp <= 1'b0;
         end else if (stop_det) begin
            st <= ST_IDLE;  cnt <= '0;  resp <= 1'b0;
         end else if (st != ST_IDLE) begin
            if (rise) begin
               if (cnt < SLOT)  shreg <= {shreg[DATA_W-2:0], sda_s};
               if (cnt == SLOT) mnack <= sda_s;
               if (cnt < DONE)  cnt <= cnt + CNT_W'(1);
            end else if (fall) begin
               if (cnt == SLOT) begin
                  resp <= 1'b1;
                  unique case (st)
                     ST_ADDR: begin
                        if (shreg == WR_CODE) st <= ST_PTR;
                        else if (shreg == RD_CODE) begin
                           st <= ST_RDATA;  first_rd <= 1'b1;
                        end else begin
                           st <= ST_IDLE;   resp <= 1'b0;
                        end
                     end
                     ST_PTR: begin
                        ptr <= shreg[ADDR_W-1:0];
                        st  <= ST_WDATA;
                     end
                     ST_WDATA: begin
                        wr_en <= 1'b1;  wr_data <= shreg;
                     end
                     default: resp <= 1'b0;
                  endcase
               end else if (cnt == DONE) begin
                  cnt  <= '0;
                  resp <= 1'b0;
                  if (st == ST_RDATA) begin
                     if (first_rd || !mnack) begin
                        txbuf    <= rd_data;
                        ptr      <= ptr + ADDR_W'(1);
                        first_rd <= 1'b0;
                        resp     <= ~rd_data[DATA_W-1];
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end else if (st == ST_RDATA && cnt != '0) begin
                  resp <= ~txbuf[bsel];
               end
            end
         end
      end
   end

   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !resp);

   // R1
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (st == ST_IDLE && !resp));

   // R6
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ptr == '1) |=> ptr == '0);

   // R9
   rd_slot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RDATA && fall && cnt == SLOT && !start_det && !stop_det) |=> !resp);

   // R3
   wr_addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && fall && cnt == SLOT && shreg == WR_CODE) |=> resp);
endmodule

// File: rtl/ser_regbank.sv
module ser_regbank #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-2:0] DEV_ID = 7'h12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_clk,
   input  logic              bus_dat,
   output logic              bus_resp,
   input  logic [ADDR_W-1:0] tap_addr,
   output logic [DATA_W-1:0] tap_data
);
   logic [1:0]        pins_s;
   logic              wr_en;
   logic [ADDR_W-1:0] ptr;
   logic [DATA_W-1:0] wr_data, rd_data;

   ser_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk (clk), .rst_n (rst_n),
      .din ({bus_clk, bus_dat}), .dout (pins_s)
   );

   ser_link #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_link (
      .clk (clk), .rst_n (rst_n),
      .scl_s (pins_s[1]), .sda_s (pins_s[0]),
      .rd_data (rd_data), .resp (bus_resp),
      .wr_en (wr_en), .ptr (ptr), .wr_data (wr_data)
   );

   ser_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr_en), .wr_addr (ptr), .wr_data (wr_data),
      .rd_addr (ptr), .rd_data (rd_data),
      .tap_addr (tap_addr), .tap_data (tap_data)
   );
endmodule

// File: tb/ser_regbank_test.sv
module ser_regbank_test;
   localparam int Q = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_clk = 1'b1;
   logic       bus_dat = 1'b1;
   logic [6:0] tap_addr = '0;
   logic       bus_resp;
   logic [7:0] tap_data;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   logic [7:0] exp_q [$];
   logic [7:0] got_q [$];
   string      tag_q [$];

   always #10 clk = ~clk;

   ser_regbank uut (
      .clk (clk), .rst_n (rst_n), .bus_clk (bus_clk), .bus_dat (bus_dat),
      .bus_resp (bus_resp), .tap_addr (tap_addr), .tap_data (tap_data)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bit_io(input logic b, output logic r);
      tick(Q); bus_dat = b;
      tick(Q); bus_clk = 1'b1;
      tick(Q); r = bus_resp;
      tick(Q); bus_clk = 1'b0;
   endtask

   task automatic start_c();
      if (bus_clk == 1'b0) begin
         tick(Q); bus_dat = 1'b1;
         tick(Q); bus_clk = 1'b1;
      end
      tick(Q); bus_dat = 1'b0;
      tick(Q); bus_clk = 1'b0;
   endtask

   task automatic stop_c();
      tick(Q); bus_dat = 1'b0;
      tick(Q); bus_clk = 1'b1;
      tick(Q); bus_dat = 1'b1;
      tick(Q);
      check("R1 response low after stop", {7'b0, bus_resp}, 8'h00);
   endtask

   task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string req);
      logic r;
      for (int i = 7; i >= 0; i--) bit_io(v[i], r);
      bit_io(1'b1, r);
      check(req, {7'b0, r}, {7'b0, exp_ack});
   endtask

   // driver side of the scoreboard: expected byte is queued, observed byte follows
   task automatic recv_byte(input logic host_ack, input logic [7:0] exp, input string req);
      logic       r;
      logic [7:0] v;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, r);
         v[i] = ~r;
      end
      got_q.push_back(v);
      bit_io(host_ack ? 1'b0 : 1'b1, r);
      check("R9 response low in read acknowledge slot", {7'b0, r}, 8'h00);
   endtask

   task automatic tap(input logic [6:0] a, input logic [7:0] exp, input string req);
      tap_addr = a;
      tick(1);
      check(req, tap_data, exp);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // monitor side of the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         while (got_q.size() > 0 && exp_q.size() > 0) begin
            check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic r;
      tick(4);
      // R10: reset state
      check("R10 response low in reset", {7'b0, bus_resp}, 8'h00);
      tap(7'h00, 8'h00, "R10 reg 00h cleared");
      tap(7'h7F, 8'h00, "R10 reg 7Fh cleared");
      rst_n = 1'b1;
      tick(4);

      // single write
      start_c();
      send_byte(8'h24, 1'b1, "R3 write address acknowledged");
      send_byte(8'h00, 1'b1, "R7 pointer byte acknowledged");
      send_byte(8'hAA, 1'b1, "R7 data byte acknowledged");
      stop_c();
      tap(7'h00, 8'hAA, "R5 single write stored, R11 lookup");

      // burst write with pointer bit 7 set (ignored): 84h -> 04h
      start_c();
      send_byte(8'h24, 1'b1, "R3 write address acknowledged");
      send_byte(8'h84, 1'b1, "R7 pointer byte acknowledged");
      send_byte(8'hFF, 1'b1, "R7 data byte acknowledged");
      send_byte(8'h80, 1'b1, "R7 data byte acknowledged");
      send_byte(8'h01, 1'b1, "R7 data byte acknowledged");
      stop_c();
      tap(7'h04, 8'hFF, "R5 burst reg 04h");
      tap(7'h05, 8'h80, "R2 MSB-first reg 05h");
      tap(7'h06, 8'h01, "R2 LSB reg 06h");

      // read back 04h..06h
      start_c();
      send_byte(8'h24, 1'b1, "R3 write address acknowledged");
      send_byte(8'h04, 1'b1, "R7 pointer byte acknowledged");
      stop_c();
      start_c();
      send_byte(8'h25, 1'b1, "R3 read address acknowledged");
      recv_byte(1'b1, 8'hFF, "R8 readout reg 04h");
      recv_byte(1'b1, 8'h80, "R8 readout reg 05h");
      recv_byte(1'b0, 8'h01, "R8 readout reg 06h");
      for (int i = 0; i < 9; i++) begin
         bit_io(1'b1, r);
         check("R9 silent after host no-acknowledge", {7'b0, r}, 8'h00);
      end
      stop_c();

      // foreign address ignored
      start_c();
      send_byte(8'h30, 1'b0, "R4 foreign address not acknowledged");
      send_byte(8'h05, 1'b0, "R4 no acknowledge after foreign address");
      send_byte(8'h55, 1'b0, "R4 no acknowledge after foreign address");
      stop_c();
      tap(7'h05, 8'h80, "R4 reg 05h untouched");

      // bytes outside a transfer ignored
      send_byte(8'h24, 1'b0, "R1 no acknowledge without start");
      send_byte(8'h03, 1'b0, "R1 no acknowledge without start");
      send_byte(8'h77, 1'b0, "R1 no acknowledge without start");
      tap(7'h03, 8'h00, "R1 reg 03h untouched");
      stop_c();

      // pointer wrap on write
      start_c();
      send_byte(8'h24, 1'b1, "R3 write address acknowledged");
      send_byte(8'h7F, 1'b1, "R7 pointer byte acknowledged");
      send_byte(8'h11, 1'b1, "R7 data byte acknowledged");
      send_byte(8'h22, 1'b1, "R7 data byte acknowledged");
      stop_c();
      tap(7'h7F, 8'h11, "R6 reg 7Fh written");
      tap(7'h00, 8'h22, "R6 write wrapped to 00h");

      // pointer wrap on read, entered by repeated start
      start_c();
      send_byte(8'h24, 1'b1, "R3 write address acknowledged");
      send_byte(8'h7F, 1'b1, "R7 pointer byte acknowledged");
      start_c();
      send_byte(8'h25, 1'b1, "R1 R3 read address after repeated start");
      recv_byte(1'b1, 8'h11, "R8 readout reg 7Fh");
      recv_byte(1'b0, 8'h22, "R6 readout wrapped to 00h");
      stop_c();

      tick(4);
      while (got_q.size() > 0) tick(1);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule